// File: doc/BRIEF.md
# 4x4 SAD Engine with Minimum Tracking

This block scores one 4x4 reference candidate against a 4x4 current block of 8-bit pixels and keeps the best score seen since the last clear. Two independent word-wide load ports fill its pixel storage. One port carries current-block pixels and the other carries reference-block pixels. Each 32-bit write fills one row of four pixels.

When the loaded pair is ready, a one-cycle `start` evaluates it. The block forms sixteen absolute differences in parallel and reduces them through four row adders and one final adder. On the next edge it registers the sum and pulses `done`. The same edge compares the sum with the stored minimum. A strictly smaller sum replaces the minimum and records the candidate's index. Candidate indices count evaluations since the last clear.

A typical caller keeps the current block loaded, streams reference candidates in, starts each one, and reads `min_sad`/`min_idx` after the last candidate. A `clr` input readies the block for a new search.

Top module: `sad4x4_min_tracker`

## Requirements
- R1: During and directly after a synchronous reset, `done` is 0, `sad` is 0, `min_sad` is all ones (4095) and `min_idx` is 0.
- R2: A write on either load port stores its word into the row named by the 2-bit row field. Bits [8j+7:8j] hold column j. Current and reference pixels with the same row and column are paired for the difference.
- R3: An evaluation's `sad` is the sum over all sixteen positions of |current − reference|. The result is correct whichever pixel of each pair is larger.
- R4: `done` is high for exactly the cycle after each cycle with `start` high, and `sad` takes its new value in that same cycle. Without `start`, `sad` holds its value.
- R5: An evaluation uses the pixel values stored before the `start` cycle's edge. A load word written in the same cycle as `start` affects only later evaluations.
- R6: `min_sad` and `min_idx` change on an evaluation only when its SAD is strictly smaller than the stored minimum. `min_idx` then takes the index of that evaluation.
- R7: An evaluation whose SAD equals the stored minimum leaves `min_sad` and `min_idx` unchanged, so the earlier candidate is kept.
- R8: The first evaluation after reset or clear has index 0. Each further evaluation has the next index, modulo 2^IDX_W.
- R9: A `clr` without `start` sets `min_sad` to all ones and `min_idx` to 0 on the next edge, resets the index counter, and leaves `sad` unchanged.
- R10: If `clr` and `start` are both high in the same cycle, the clear applies first. That evaluation becomes index 0 and is always accepted as the minimum.
- R11: The largest possible SAD (4080, all pairs 0 against 255) and the smallest (0) are produced exactly. A SAD of 4080 is accepted as the first candidate after a clear.
- R12: Load writes without `start` change none of `done`, `sad`, `min_sad` and `min_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cur_we | input | 1 | Write strobe for the current-block port |
| cur_row | input | 2 | Row selected by a current-block write |
| cur_word | input | 32 | Four current pixels, column 0 in the low byte |
| ref_we | input | 1 | Write strobe for the reference-block port |
| ref_row | input | 2 | Row selected by a reference-block write |
| ref_word | input | 32 | Four reference pixels, column 0 in the low byte |
| clr | input | 1 | Reset the stored minimum and the candidate counter |
| start | input | 1 | Evaluate the stored pixel pair |
| done | output | 1 | One-cycle flag that `sad` holds a new result |
| sad | output | 12 | SAD of the last evaluation |
| min_sad | output | 12 | Smallest SAD since the last clear |
| min_idx | output | 8 | Index of the candidate that gave `min_sad` |

## Verification
A pixel register stored in the wrong row or byte lane shows up in the very next `sad` as a mispairing. The bench loads rows with byte orders that differ between the two ports, so such a fault cannot cancel out. A broken absolute value or adder-tree lane gives a wrong `sad` one cycle after `start`. A fault in the minimum comparison or the index counter shows in `min_sad`/`min_idx` in that same cycle. A tie handled as a replacement shows as a changed index. A fault in the clear path shows one cycle after `clr`, or as a wrong index on the first candidate after it.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Bits needed to select one of n rows (at least one bit).
  function automatic int row_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bits for a sum of npix unsigned pixels of pix_w bits.
  function automatic int sad_bits(input int pix_w, input int npix);
    return pix_w + ((npix > 1) ? $clog2(npix) : 0);
  endfunction

  // Largest value a SAD can take.
  function automatic int sad_max(input int pix_w, input int npix);
    return npix * ((1 << pix_w) - 1);
  endfunction

endpackage

// File: rtl/sad_pixel_bank.sv
module sad_pixel_bank #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 4,
  parameter int COLS  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [sad_pkg::row_bits(ROWS)-1:0] row,
  input  logic [COLS*PIX_W-1:0]       word,
  output logic [ROWS*COLS*PIX_W-1:0]  pix_flat
);
  localparam int WORD_W = COLS * PIX_W;

  // All rows are read in parallel every cycle, so the bank stays in flops.
  logic [WORD_W-1:0] rows_q [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
    end else if (we && (int'(row) < ROWS)) begin
      rows_q[row] <= word;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_flat
    assign pix_flat[r*WORD_W +: WORD_W] = rows_q[r];
  end

endmodule

// File: rtl/sad_absdiff_tree.sv
module sad_absdiff_tree #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 4,
  parameter int COLS  = 4
) (
  input  logic [ROWS*COLS*PIX_W-1:0] cur_flat,
  input  logic [ROWS*COLS*PIX_W-1:0] ref_flat,
  output logic [sad_pkg::sad_bits(PIX_W, ROWS*COLS)-1:0] sad
);
  localparam int NPIX  = ROWS * COLS;
  localparam int ROW_W = sad_pkg::sad_bits(PIX_W, COLS);
  localparam int SAD_W = sad_pkg::sad_bits(PIX_W, NPIX);

  logic [PIX_W-1:0] absd [NPIX];
  logic [ROW_W-1:0] rsum [ROWS];

  // Sixteen parallel subtract-and-magnitude lanes.
  always_comb begin
    for (int i = 0; i < NPIX; i++) begin
      logic [PIX_W-1:0] a, b;
      a = cur_flat[i*PIX_W +: PIX_W];
      b = ref_flat[i*PIX_W +: PIX_W];
      absd[i] = (a >= b) ? (a - b) : (b - a);
    end
  end

  // First level: one adder per row.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_comb begin
      rsum[r] = '0;
      for (int c = 0; c < COLS; c++)
        rsum[r] = rsum[r] + ROW_W'(absd[r*COLS + c]);
    end
  end

  // Second level: add the row sums.
  always_comb begin
    sad = '0;
    for (int r = 0; r < ROWS; r++)
      sad = sad + SAD_W'(rsum[r]);
  end

endmodule

// File: rtl/sad_min_keeper.sv
module sad_min_keeper #(
  parameter int SAD_W = 12,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             clr,
  input  logic [SAD_W-1:0] sad_in,
  output logic             done,
  output logic [SAD_W-1:0] sad_q,
  output logic [SAD_W-1:0] min_q,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] cnt_q;
  logic [SAD_W-1:0] base_min;
  logic [IDX_W-1:0] base_cnt;
  logic [IDX_W-1:0] base_idx;
  logic             better;

  // A clear applies ahead of a candidate evaluated in the same cycle.
  always_comb begin
    base_min = clr ? '1 : min_q;
    base_cnt = clr ? '0 : cnt_q;
    base_idx = clr ? '0 : idx_q;
    better   = (sad_in < base_min);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      sad_q <= '0;
      min_q <= '1;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      done <= start;
      if (start) begin
        sad_q <= sad_in;
        cnt_q <= base_cnt + 1'b1;
        min_q <= better ? sad_in : base_min;
        idx_q <= better ? base_cnt : base_idx;
      end else if (clr) begin
        min_q <= '1;
        idx_q <= '0;
        cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/sad4x4_min_tracker.sv
module sad4x4_min_tracker #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int IDX_W = 8
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           cur_we,
  input  logic [sad_pkg::row_bits(ROWS)-1:0]             cur_row,
  input  logic [COLS*PIX_W-1:0]                          cur_word,
  input  logic                                           ref_we,
  input  logic [sad_pkg::row_bits(ROWS)-1:0]             ref_row,
  input  logic [COLS*PIX_W-1:0]                          ref_word,
  input  logic                                           clr,
  input  logic                                           start,
  output logic                                           done,
  output logic [sad_pkg::sad_bits(PIX_W, ROWS*COLS)-1:0] sad,
  output logic [sad_pkg::sad_bits(PIX_W, ROWS*COLS)-1:0] min_sad,
  output logic [IDX_W-1:0]                               min_idx
);
  localparam int NPIX   = ROWS * COLS;
  localparam int FLAT_W = NPIX * PIX_W;
  localparam int SAD_W  = sad_pkg::sad_bits(PIX_W, NPIX);

  logic [FLAT_W-1:0] cur_flat;
  logic [FLAT_W-1:0] ref_flat;
  logic [SAD_W-1:0]  sad_comb;

  sad_pixel_bank #(.PIX_W(PIX_W), .ROWS(ROWS), .COLS(COLS)) u_cur_bank (
    .clk(clk), .rst(rst), .we(cur_we), .row(cur_row), .word(cur_word),
    .pix_flat(cur_flat)
  );

  sad_pixel_bank #(.PIX_W(PIX_W), .ROWS(ROWS), .COLS(COLS)) u_ref_bank (
    .clk(clk), .rst(rst), .we(ref_we), .row(ref_row), .word(ref_word),
    .pix_flat(ref_flat)
  );

  sad_absdiff_tree #(.PIX_W(PIX_W), .ROWS(ROWS), .COLS(COLS)) u_tree (
    .cur_flat(cur_flat), .ref_flat(ref_flat), .sad(sad_comb)
  );

  sad_min_keeper #(.SAD_W(SAD_W), .IDX_W(IDX_W)) u_keep (
    .clk(clk), .rst(rst), .start(start), .clr(clr), .sad_in(sad_comb),
    .done(done), .sad_q(sad), .min_q(min_sad), .idx_q(min_idx)
  );

endmodule

// File: rtl/sad_min_checker.sv
module sad_min_checker #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int IDX_W = 8
) (
  input logic                                           clk,
  input logic                                           rst,
  input logic                                           clr,
  input logic                                           start,
  input logic                                           done,
  input logic [sad_pkg::sad_bits(PIX_W, ROWS*COLS)-1:0] sad,
  input logic [sad_pkg::sad_bits(PIX_W, ROWS*COLS)-1:0] min_sad,
  input logic [IDX_W-1:0]                               min_idx
);
  localparam int SAD_W   = sad_pkg::sad_bits(PIX_W, ROWS*COLS);
  localparam int SAD_TOP = sad_pkg::sad_max(PIX_W, ROWS*COLS);

  // R4: done follows start by one cycle
  p_done_after_start_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  p_no_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  // R4: result holds between evaluations
  p_sad_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(sad));
  // R11: a result never exceeds the largest SAD
  p_sad_range_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(sad) <= SAD_TOP));
  // R6: minimum never grows without a clear
  p_min_monotone_r6: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (min_sad <= $past(min_sad)));
  // R6: after an evaluation the minimum is no larger than its SAD
  p_min_le_sad_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> (min_sad <= sad));
  // R9: a lone clear restores the empty state
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !start) |=> ((min_sad == {SAD_W{1'b1}}) && (min_idx == '0)));
  // R12: index only moves on an evaluation or a clear
  p_idx_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!start && !clr) |=> ($stable(min_idx) && $stable(min_sad)));

endmodule

bind sad4x4_min_tracker sad_min_checker #(
  .PIX_W(PIX_W), .ROWS(ROWS), .COLS(COLS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .start(start), .done(done),
  .sad(sad), .min_sad(min_sad), .min_idx(min_idx)
);

// File: tb/tb_sad4x4_min_tracker.sv
module tb_sad4x4_min_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cur_we = 1'b0, ref_we = 1'b0;
  logic [1:0]  cur_row = '0, ref_row = '0;
  logic [31:0] cur_word = '0, ref_word = '0;
  logic        clr = 1'b0, start = 1'b0;
  logic        done;
  logic [11:0] sad, min_sad;
  logic [7:0]  min_idx;

  sad4x4_min_tracker dut (
    .clk(clk), .rst(rst), .cur_we(cur_we), .cur_row(cur_row), .cur_word(cur_word),
    .ref_we(ref_we), .ref_row(ref_row), .ref_word(ref_word), .clr(clr),
    .start(start), .done(done), .sad(sad), .min_sad(min_sad), .min_idx(min_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Bench model
  logic [7:0] m_cur [16];
  logic [7:0] m_ref [16];
  int m_min = 4095, m_idx = 0, m_cnt = 0, m_sad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic int model_sad();
    int s = 0;
    for (int i = 0; i < 16; i++)
      s += (m_cur[i] >= m_ref[i]) ? int'(m_cur[i]) - int'(m_ref[i])
                                  : int'(m_ref[i]) - int'(m_cur[i]);
    return s;
  endfunction

  function automatic logic [31:0] pack(input logic [7:0] p [16], input int r);
    return {p[r*4+3], p[r*4+2], p[r*4+1], p[r*4]};
  endfunction

  // Write one row on both ports in the same cycle.
  task automatic wr_both(input int r, input logic [31:0] cw, input logic [31:0] rw);
    cur_we = 1; cur_row = 2'(r); cur_word = cw;
    ref_we = 1; ref_row = 2'(r); ref_word = rw;
    for (int j = 0; j < 4; j++) begin
      m_cur[r*4+j] = cw[j*8 +: 8];
      m_ref[r*4+j] = rw[j*8 +: 8];
    end
    @(negedge clk);
    cur_we = 0; ref_we = 0;
  endtask

  task automatic load(input logic [7:0] c [16], input logic [7:0] f [16]);
    for (int r = 0; r < 4; r++) wr_both(r, pack(c, r), pack(f, r));
  endtask

  // Start an evaluation (optionally with clear and a same-cycle current write).
  task automatic eval(input string req, input bit with_clr,
                      input bit wr, input int r, input logic [31:0] w);
    int s;
    s = model_sad();
    start = 1; clr = with_clr;
    if (wr) begin
      cur_we = 1; cur_row = 2'(r); cur_word = w;
      for (int j = 0; j < 4; j++) m_cur[r*4+j] = w[j*8 +: 8];
    end
    if (with_clr) begin m_cnt = 0; m_min = 4095; m_idx = 0; end
    if (s < m_min) begin m_min = s; m_idx = m_cnt; end
    m_cnt = (m_cnt + 1) % 256;
    m_sad = s;
    @(negedge clk);
    start = 0; clr = 0; cur_we = 0;
    chk(req, "done pulse", int'(done), 1);
    chk(req, "sad", int'(sad), m_sad);
    chk(req, "min_sad", int'(min_sad), m_min);
    chk(req, "min_idx", int'(min_idx), m_idx);
    @(negedge clk);
    chk("R4", "done low after pulse", int'(done), 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) begin m_cur[i] = 0; m_ref[i] = 0; end
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "done", int'(done), 0);
    chk("R1", "sad", int'(sad), 0);
    chk("R1", "min_sad", int'(min_sad), 4095);
    chk("R1", "min_idx", int'(min_idx), 0);
  endtask

  task automatic t_basic;
    logic [7:0] c [16], f [16];
    for (int i = 0; i < 16; i++) begin c[i] = 8'(i*17); f[i] = 8'(200 - i*9); end
    load(c, f);
    eval("R3", 0, 0, 0, 0); // mixed signs, candidate 0 accepted
  endtask

  task automatic t_load_only_then_better;
    logic [7:0] c [16], f [16];
    for (int i = 0; i < 16; i++) begin c[i] = 8'(50 + i); f[i] = 8'(50 + i); end
    f[5] = 8'(58); f[12] = 8'(60); // SAD 3 + 2 = 5
    load(c, f);
    @(negedge clk);
    chk("R12", "done after loads", int'(done), 0);
    chk("R12", "sad after loads", int'(sad), m_sad);
    chk("R12", "min_sad after loads", int'(min_sad), m_min);
    chk("R12", "min_idx after loads", int'(min_idx), m_idx);
    eval("R6", 0, 0, 0, 0); // smaller SAD replaces, index 1 (R8)
    chk("R8", "second candidate index", int'(min_idx), 1);
  endtask

  task automatic t_tie_and_worse;
    int keep;
    keep = m_idx;
    eval("R7", 0, 0, 0, 0);
    chk("R7", "tie keeps earlier index", int'(min_idx), keep);
    wr_both(0, 32'hFF00FF00, 32'h00FF00FF);
    eval("R6", 0, 0, 0, 0);
    chk("R6", "worse keeps index", int'(min_idx), keep);
  endtask

  task automatic t_lane_pairing;
    for (int r = 0; r < 4; r++) wr_both(r, 32'h0, 32'h0);
    wr_both(1, 32'h04030201, 32'h01020304);
    eval("R2", 1, 0, 0, 0); // 3+1+1+3 = 8
    chk("R2", "byte lane pairing", int'(sad), 8);
    wr_both(1, 32'h04030201, 32'h04030201);
    cur_we = 0;
    ref_we = 1; ref_row = 2'd2; ref_word = 32'h04030201;
    for (int j = 0; j < 4; j++) m_ref[8+j] = 8'(j+1);
    @(negedge clk);
    ref_we = 0;
    eval("R2", 0, 0, 0, 0);
    chk("R2", "row selection", int'(sad), 10);
  endtask

  task automatic t_clear;
    logic [11:0] keep_sad;
    keep_sad = sad;
    clr = 1;
    @(negedge clk);
    clr = 0;
    m_min = 4095; m_idx = 0; m_cnt = 0;
    chk("R9", "min_sad after clear", int'(min_sad), 4095);
    chk("R9", "min_idx after clear", int'(min_idx), 0);
    chk("R9", "sad kept by clear", int'(sad), int'(keep_sad));
    eval("R8", 0, 0, 0, 0);
    chk("R8", "first index after clear", int'(min_idx), 0);
  endtask

  task automatic t_clear_with_start;
    logic [7:0] c [16], f [16];
    for (int i = 0; i < 16; i++) begin c[i] = 8'd100; f[i] = 8'd90; end
    load(c, f);
    eval("R8", 0, 0, 0, 0);
    load(c, f);
    for (int r = 0; r < 4; r++) wr_both(r, 32'h0, 32'hFFFFFFFF);
    eval("R10", 1, 0, 0, 0);
    chk("R10", "worse SAD accepted with clear", int'(min_sad), 4080);
    chk("R11", "max SAD", int'(sad), 4080);
    chk("R10", "index 0 with clear", int'(min_idx), 0);
  endtask

  task automatic t_extremes;
    for (int r = 0; r < 4; r++) wr_both(r, 32'h5A5AA5A5, 32'h5A5AA5A5);
    eval("R11", 0, 0, 0, 0);
    chk("R11", "zero SAD", int'(sad), 0);
    chk("R11", "zero min index", int'(min_idx), 1);
  endtask

  task automatic t_same_cycle_write;
    for (int r = 0; r < 4; r++) wr_both(r, 32'h10101010, 32'h10101010);
    eval("R5", 1, 1, 0, 32'h20202020); // evaluated on old values: SAD 0
    chk("R5", "write with start unseen", int'(sad), 0);
    eval("R5", 0, 0, 0, 0);            // now 4*16 = 64
    chk("R5", "write seen next time", int'(sad), 64);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_load_only_then_better();
    t_tie_and_worse();
    t_lane_pairing();
    t_clear();
    t_clear_with_start();
    t_extremes();
    t_same_cycle_write();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule